// File: doc/BRIEF.md
# Socket Status Change Latch

This block is the per-socket event register that collects changes on a removable card's status lines and turns them into one management interrupt. Four card lines feed it: a card-sense line, a ready/interrupt-request line, and two battery-voltage lines. Each line is brought into the clock domain by a two-flop synchronizer. An edge detector compares each synchronized sample with the one before it. A per-bit rule then decides which edge direction counts. That rule depends on whether the socket runs memory cards or I/O cards.

A latched bit stays set until software clears it. Clearing takes two steps. First the host touches the companion card-status register, which arms the clear. Then the host writes 1 to the bit. A separate enable vector masks both the latching of events and the interrupt. The register reads back with its upper nibble tied to zero.

Top module: `sock_evt_latch`

## Requirements
- R1: After reset all status bits read 0 and `mgmt_irq` is 0. Bits 7:4 of `reg_rdata` always read 0, even after a write of 1s to them. `reg_rdata` shows the current register contents at all times.
- R2: Bit 3 latches any transition, rising or falling, on `card_sense`. Bit 2 latches any transition on `ready_line`. Both rules apply in either mode.
- R3: With `io_mode`=0 (memory cards), bit 0 sets on a high-to-low transition of `batt_a`. A low-to-high transition has no effect.
- R4: With `io_mode`=1 (I/O cards), bit 0 sets on either transition of `batt_a`.
- R5: With `io_mode`=0, bit 1 sets on a high-to-low transition of `batt_b`. A low-to-high transition has no effect.
- R6: With `io_mode`=1, no transition of `batt_b` sets bit 1.
- R7: A set bit clears only when the write is armed: `status_touch` is pulsed in an earlier cycle, and then a write (`reg_wr_en`) with 1 in that bit position follows. An unarmed write-1 leaves the bit set. A write of 0 never clears a bit.
- R8: The arm is consumed by the first write after it, whether or not that write clears anything. A write in the same cycle as `status_touch` clears nothing and leaves the arm in place for the next write.
- R9: An event on a line whose `evt_en` bit is 0 is not latched. Setting the enable afterwards does not latch it retroactively.
- R10: `mgmt_irq` is active-high and is the OR of (status bit AND `evt_en` bit) over bits 3:0.
- R11: If an event and an armed clear of the same bit land in the same cycle, the bit stays set.
- R12: Changing `io_mode` does not alter bits that are already latched.
- R13: A line change made between clock edges shows in `reg_rdata` after the third rising edge, and not after the second. Line levels present during the first three cycles after reset produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_mode | input | 1 | 0 = memory-card socket, 1 = I/O-card socket |
| card_sense | input | 1 | Card-sense line (asynchronous) |
| ready_line | input | 1 | Ready / interrupt-request line (asynchronous) |
| batt_a | input | 1 | First battery-voltage / status-change line (asynchronous) |
| batt_b | input | 1 | Second battery-voltage line (asynchronous) |
| evt_en | input | 4 | Per-bit event enable, bit i enables status bit i |
| status_touch | input | 1 | Pulse when the host accesses the companion card-status register |
| reg_wr_en | input | 1 | Write strobe for this register |
| reg_wdata | input | 8 | Write data; a 1 requests a clear of that bit |
| reg_rdata | output | 8 | Register contents: bits 3:0 status, 7:4 zero |
| mgmt_irq | output | 1 | Management interrupt, active-high |

## Verification
The bench targets the arming sequence. It tries an unarmed write-1, an armed write of 0 followed by a write-1 that should find the arm used up, and a write issued in the same cycle as the arm pulse. A design that forgets to consume the arm, or that clears on any write-1, leaves or drops a bit at the wrong moment. The bench also lines up an armed clear with a fresh edge of the same line in the same cycle, where a clear-wins design loses the event. It swaps modes to catch a rising battery edge latched in memory mode, a second battery bit that sets in I/O mode, and a mode switch that wipes latched bits. Finally, it counts the exact synchronizer latency to catch a stage too many or too few.

// File: rtl/sock_evt_pkg.sv
// Package: shared constants and the per-bit edge rule for the socket
// status change latch. Assumes four status bits in the low nibble.
package sock_evt_pkg;

    localparam int NUM_EVT  = 4;
    localparam int REG_W    = 8;
    localparam int SYNC_LEN = 2;

    localparam int BIT_BATT_A = 0;
    localparam int BIT_BATT_B = 1;
    localparam int BIT_READY  = 2;
    localparam int BIT_CARD   = 3;

    typedef enum logic [1:0] {
        EK_NONE = 2'd0,
        EK_FALL = 2'd1,
        EK_ANY  = 2'd2
    } edge_kind_e;

    // Which edge direction a given status bit latches on in a given mode.
    function automatic edge_kind_e kind_of(input int idx, input logic io);
        edge_kind_e k;
        case (idx)
            BIT_CARD:   k = EK_ANY;
            BIT_READY:  k = EK_ANY;
            BIT_BATT_A: k = io ? EK_ANY  : EK_FALL;
            BIT_BATT_B: k = io ? EK_NONE : EK_FALL;
            default:    k = EK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sock_evt_sync.sv
// Module: brings W asynchronous lines into the clock domain through a
// SYNC_LEN flop chain and reports rising/falling edges against the prior
// synchronized sample. Edges are suppressed until the chain and the
// previous-sample flop hold real line values after reset.
module sock_evt_sync #(
    parameter int W        = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int WARM = SYNC_LEN + 1;

    logic [W-1:0] chain [SYNC_LEN];
    logic [W-1:0] prev_q;
    logic [WARM-1:0] warm_q;

    // Synchronizer chain, one stage per generate slice.
    genvar g;
    generate
        for (g = 0; g < SYNC_LEN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized sample and warm-up qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            warm_q <= '0;
        end else begin
            prev_q <= chain[SYNC_LEN-1];
            warm_q <= {warm_q[WARM-2:0], 1'b1};
        end
    end

    // Edge report, gated until the samples are trustworthy.
    always_comb begin
        level = chain[SYNC_LEN-1];
        rise  = warm_q[WARM-1] ? (level & ~prev_q) : '0;
        fall  = warm_q[WARM-1] ? (~level & prev_q) : '0;
    end

endmodule

// File: rtl/sock_evt_rule.sv
// Module: applies the mode-dependent edge rule per status bit and
// produces one hit per bit. Purely combinational; assumes rise/fall are
// single-cycle pulses from the synchronizer.
module sock_evt_rule
    import sock_evt_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         io_mode,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] fall,
    output logic [N-1:0] hit
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            // Select which edge counts for this bit in the current mode.
            always_comb begin
                case (kind_of(g, io_mode))
                    EK_ANY:  hit[g] = rise[g] | fall[g];
                    EK_FALL: hit[g] = fall[g];
                    default: hit[g] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/sock_evt_bits.sv
// Module: holds the latched status bits and the clear-arm flag. An arm
// is set by a companion-register access and consumed by the next write;
// an armed write-1 clears a bit unless a new hit lands the same cycle.
module sock_evt_bits #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] en,
    input  logic         touch,
    input  logic         wr_en,
    input  logic [N-1:0] wr_ones,
    output logic [N-1:0] status,
    output logic         armed
);
    logic [N-1:0] clr_req;
    logic [N-1:0] set_req;

    // Clear and set requests for this cycle.
    always_comb begin
        clr_req = (wr_en && armed) ? wr_ones : '0;
        set_req = hit & en;
    end

    // Arm flag: a touch arms, any write without a touch disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (touch) armed <= 1'b1;
        else if (wr_en) armed <= 1'b0;
    end

    // Status bits: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_req) | set_req;
    end

endmodule

// File: rtl/sock_evt_latch.sv
// Module: top of the socket status change latch. Synchronizes four card
// lines, applies the mode rule, latches enabled events, and drives an
// active-high management interrupt. Assumes lines are asynchronous and
// that status_touch and reg_wr_en are single-cycle strobes.
module sock_evt_latch
    import sock_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_mode,
    input  logic             card_sense,
    input  logic             ready_line,
    input  logic             batt_a,
    input  logic             batt_b,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic             status_touch,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mgmt_irq
);
    logic [NUM_EVT-1:0] lines_w;
    logic [NUM_EVT-1:0] lvl_w;
    logic [NUM_EVT-1:0] rise_w;
    logic [NUM_EVT-1:0] fall_w;
    logic [NUM_EVT-1:0] hit_w;
    logic [NUM_EVT-1:0] status_w;
    logic               armed_w;

    // Gather the lines in status-bit order.
    always_comb begin
        lines_w             = '0;
        lines_w[BIT_BATT_A] = batt_a;
        lines_w[BIT_BATT_B] = batt_b;
        lines_w[BIT_READY]  = ready_line;
        lines_w[BIT_CARD]   = card_sense;
    end

    sock_evt_sync #(.W(NUM_EVT), .SYNC_LEN(SYNC_LEN)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (lines_w),
        .level   (lvl_w),
        .rise    (rise_w),
        .fall    (fall_w)
    );

    sock_evt_rule #(.N(NUM_EVT)) rule_i (
        .io_mode (io_mode),
        .rise    (rise_w),
        .fall    (fall_w),
        .hit     (hit_w)
    );

    sock_evt_bits #(.N(NUM_EVT)) bits_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit_w),
        .en      (evt_en),
        .touch   (status_touch),
        .wr_en   (reg_wr_en),
        .wr_ones (reg_wdata[NUM_EVT-1:0]),
        .status  (status_w),
        .armed   (armed_w)
    );

    // Read-back view and interrupt.
    always_comb begin
        reg_rdata              = '0;
        reg_rdata[NUM_EVT-1:0] = status_w;
        mgmt_irq               = |(status_w & evt_en);
    end

endmodule

// File: rtl/sock_evt_latch_chk.sv
// Checker: temporal properties of the socket status change latch, bound
// to the top module. Sees the armed flag and synchronized levels.
module sock_evt_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_mode,
    input logic [3:0] evt_en,
    input logic       status_touch,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       mgmt_irq,
    input logic       armed,
    input logic [3:0] lvl
);
    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_bit
            // R7
            clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(reg_rdata[g]) |-> $past(reg_wr_en && reg_wdata[g] && armed));
            // R9
            set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(reg_rdata[g]) |-> $past(evt_en[g]));
        end
    endgenerate

    // R6
    io_batt_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[1]) |-> !$past(io_mode));

    // R3
    mem_batt_a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_rdata[0]) && !$past(io_mode)) |-> !$past(lvl[0]));

    // R10
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq |-> (reg_rdata[3:0] != 4'd0));

    // R8
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr_en && !status_touch) |-> !armed);

endmodule

bind sock_evt_latch sock_evt_latch_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_mode      (io_mode),
    .evt_en       (evt_en),
    .status_touch (status_touch),
    .reg_wr_en    (reg_wr_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .mgmt_irq     (mgmt_irq),
    .armed        (armed_w),
    .lvl          (lvl_w)
);

// File: tb/sock_evt_latch_tb_top.sv
// Bench: scoreboard style. Driver tasks push expected register/irq items;
// a monitor pops one per falling clock edge and compares.
module sock_evt_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_mode = 1'b0;
    logic       card_sense = 1'b1;
    logic       ready_line = 1'b1;
    logic       batt_a = 1'b1;
    logic       batt_b = 1'b1;
    logic [3:0] evt_en = 4'hF;
    logic       status_touch = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mgmt_irq;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    sock_evt_latch dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_mode      (io_mode),
        .card_sense   (card_sense),
        .ready_line   (ready_line),
        .batt_a       (batt_a),
        .batt_b       (batt_b),
        .evt_en       (evt_en),
        .status_touch (status_touch),
        .reg_wr_en    (reg_wr_en),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .mgmt_irq     (mgmt_irq)
    );

    // Monitor: compare one expected item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (reg_rdata !== e.data || mgmt_irq !== e.irq) begin
                    n_err++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, reg_rdata, mgmt_irq, e.data, e.irq);
                end
            end
        end
    end

    task automatic expect_now(input logic [7:0] d, input logic i, input string tag);
        exp_t e;
        e.data = d; e.irq = i; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic touch();
        @(negedge clk); status_touch = 1'b1;
        @(negedge clk); status_touch = 1'b0;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic clear(input logic [7:0] d);
        touch();
        write(d);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        expect_now(8'h00, 1'b0, "R1 reset value, R13 no warm-up event");

        // R13 latency, R3 falling edge in memory mode
        @(negedge clk); batt_a = 1'b0;
        @(negedge clk);
        expect_now(8'h00, 1'b0, "R13 not yet after two edges");
        expect_now(8'h01, 1'b1, "R13 set after third edge, R3 fall");

        write(8'h01);
        expect_now(8'h01, 1'b1, "R7 unarmed write-1 keeps bit");
        touch(); write(8'h00);
        expect_now(8'h01, 1'b1, "R7 armed write of 0 keeps bit");
        write(8'h01);
        expect_now(8'h01, 1'b1, "R8 arm consumed by previous write");
        clear(8'h01);
        expect_now(8'h00, 1'b0, "R7 armed write-1 clears");

        @(negedge clk); batt_a = 1'b1; settle();
        expect_now(8'h00, 1'b0, "R3 rising batt_a ignored in memory mode");
        @(negedge clk); batt_b = 1'b0; settle();
        expect_now(8'h02, 1'b1, "R5 falling batt_b in memory mode");
        @(negedge clk); batt_b = 1'b1; settle();
        expect_now(8'h02, 1'b1, "R5 rising batt_b no effect");
        clear(8'hFF);
        expect_now(8'h00, 1'b0, "R1 reserved bits stay 0 after write of 1s");

        @(negedge clk); ready_line = 1'b0; settle();
        expect_now(8'h04, 1'b1, "R2 ready falling");
        @(negedge clk); card_sense = 1'b0; settle();
        expect_now(8'h0C, 1'b1, "R2 card sense falling");
        clear(8'h0F);
        @(negedge clk); ready_line = 1'b1; settle();
        expect_now(8'h04, 1'b1, "R2 ready rising");

        // R11 collision: new ready edge latches in the same cycle as an armed clear
        touch();
        @(negedge clk); ready_line = 1'b0;
        @(negedge clk);
        @(negedge clk); reg_wr_en = 1'b1; reg_wdata = 8'h04;
        @(negedge clk); reg_wr_en = 1'b0; reg_wdata = 8'h00;
        settle();
        expect_now(8'h04, 1'b1, "R11 set wins over same-cycle clear");
        clear(8'h04);
        expect_now(8'h00, 1'b0, "R7 clear after collision");

        @(negedge clk); batt_b = 1'b0; settle();
        @(negedge clk); io_mode = 1'b1; settle();
        expect_now(8'h02, 1'b1, "R12 mode switch keeps latched bit");
        clear(8'h02);

        @(negedge clk); batt_b = 1'b1; settle();
        @(negedge clk); batt_b = 1'b0; settle();
        expect_now(8'h00, 1'b0, "R6 batt_b ignored in I/O mode");
        @(negedge clk); batt_a = 1'b0; settle();
        expect_now(8'h01, 1'b1, "R4 falling batt_a in I/O mode");
        clear(8'h01);
        @(negedge clk); batt_a = 1'b1; settle();
        expect_now(8'h01, 1'b1, "R4 rising batt_a in I/O mode");
        clear(8'h01);

        @(negedge clk); evt_en = 4'b1011;
        @(negedge clk); ready_line = 1'b1; settle();
        expect_now(8'h00, 1'b0, "R9 disabled event not latched");
        @(negedge clk); evt_en = 4'hF; settle();
        expect_now(8'h00, 1'b0, "R9 no retroactive latch");

        @(negedge clk); card_sense = 1'b1; settle();
        expect_now(8'h08, 1'b1, "R10 irq from latched enabled bit");
        @(negedge clk); evt_en = 4'b0111;
        expect_now(8'h08, 1'b0, "R10 irq masked by enable");
        @(negedge clk); evt_en = 4'hF;

        // R8 write in the same cycle as the touch: no clear, arm stays
        @(negedge clk); status_touch = 1'b1; reg_wr_en = 1'b1; reg_wdata = 8'h08;
        @(negedge clk); status_touch = 1'b0; reg_wr_en = 1'b0; reg_wdata = 8'h00;
        expect_now(8'h08, 1'b1, "R8 write with touch does not clear");
        write(8'h08);
        expect_now(8'h00, 1'b0, "R8 arm survives same-cycle write");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule